// File: doc/BRIEF.md
# Serial Configuration Word Loader

The loader takes a configuration bitstream that an external controller clocks in by hand, one bit at a time, over two wires: a sample strobe and a data line. Both wires share pins with ordinary user inputs. The strobe sits on user input bit 0 and the data line on user input bit 1. The loader listens only while the active-low chip reset is held low. Once that reset is released it goes idle, and the pins belong to the user design.

The block runs on a system clock that must toggle faster than the strobe. The strobe is never used as a clock. Both wires are synchronised into the clock domain, and the loader takes one data bit each time it sees a clean rising edge of the synchronised strobe. Bits are packed most significant bit first into 32-bit words. Each finished word leaves with a one-clock valid pulse and a word address that counts up from zero, ready to be written into configuration storage. A fabric reset output stays high while loading is in progress, so that the user logic is held in reset.

Top module: `cfg_bitbang_loader`

## Requirements
- R1: While `porN` is low, `wordValid` is 0 and `fabricRst` is 1.
- R2: A bit is taken only on a rising edge of the synchronised strobe. Holding the strobe high for any number of clocks yields exactly one bit.
- R3: The first bit of each word lands in bit 31 of `wordData` and the 32nd bit lands in bit 0.
- R4: `wordValid` is high for exactly one clock per 32 accepted bits. It is asserted after the second clock edge following the edge that first samples the 32nd strobe high, and it carries the finished word.
- R5: The first word of a load has `wordAddr` 0. Each following word has the previous address plus one, wrapping modulo 2^ADDR_W (64 by default).
- R6: While the synchronised `rstN` is high, strobe edges are ignored and no word is produced.
- R7: Releasing `rstN` abandons any partial word and clears the address. The next load starts a fresh word at address 0.
- R8: `fabricRst` equals the inverse of `rstN` delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the strobe |
| porN | input | 1 | Active-low asynchronous power-on reset of the loader flops |
| rstN | input | 1 | Active-low chip reset; loading is enabled while it is low |
| cfgStrobe | input | 1 | Sample strobe (user input bit 0) |
| cfgData | input | 1 | Serial data bit (user input bit 1) |
| fabricRst | output | 1 | High while configuration is in progress |
| wordValid | output | 1 | One-clock pulse per finished word |
| wordData | output | WORD_W | Assembled word, MSB first |
| wordAddr | output | ADDR_W | Word address for configuration storage |

## Verification
The assertions rely on two conditions:
- `porN` is pulled low before the first clock edge.
- The strobe, data and chip-reset inputs only change away from the active clock edge, so each level is seen by at least one clock.

With these in place, the address and pulse properties only need to watch the outputs. The stimulus meets them by changing inputs only on falling clock edges. It holds every strobe level for at least one whole clock, and it varies the high and low widths from one to several clocks. Strobe activity while `rstN` is high is also driven, so the idle path is exercised within the same limits.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Strobes from control to datapath, valid for the current clock
  typedef struct packed {
    logic capture;   // take one data bit this cycle
    logic wordDone;  // this capture completes a word
    logic clear;     // loader disabled: drop state
  } ctrlStrobes_t;

endpackage

// File: rtl/cfg_loader_sync.sv
module cfg_loader_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             porN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) stage[0] <= RST_VAL;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) stage[s] <= RST_VAL;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic         clk,
  input  logic         porN,
  input  logic         strobeSync,
  input  logic         rstNSync,
  output ctrlStrobes_t ctl,
  output logic         loadEn
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic strobePrev;
  logic [CNT_W-1:0] bitCnt;
  logic strobeRise;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) strobePrev <= 1'b0;
    else       strobePrev <= strobeSync;
  end

  always_comb begin
    loadEn       = ~rstNSync;
    strobeRise   = strobeSync & ~strobePrev;
    ctl.clear    = ~loadEn;
    ctl.capture  = strobeRise & loadEn;
    ctl.wordDone = ctl.capture && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                        bitCnt <= '0;
    else if (ctl.clear)               bitCnt <= '0;
    else if (ctl.wordDone)            bitCnt <= '0;
    else if (ctl.capture)             bitCnt <= bitCnt + 1'b1;
  end

endmodule

// File: rtl/cfg_loader_dpath.sv
module cfg_loader_dpath
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              porN,
  input  ctrlStrobes_t      ctl,
  input  logic              dataSync,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic [ADDR_W-1:0] wordAddr
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;
  logic [ADDR_W-1:0] addrCnt;

  assign nextWord = {shiftReg[WORD_W-2:0], dataSync};

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)            shiftReg <= '0;
    else if (ctl.capture) shiftReg <= nextWord;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wordValid <= 1'b0;
      addrCnt   <= '0;
    end else if (ctl.clear) begin
      wordValid <= 1'b0;
      addrCnt   <= '0;
    end else begin
      wordValid <= ctl.wordDone;
      if (ctl.wordDone) addrCnt <= addrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wordData <= '0;
      wordAddr <= '0;
    end else if (ctl.wordDone) begin
      wordData <= nextWord;
      wordAddr <= addrCnt;
    end
  end

endmodule

// File: rtl/cfg_bitbang_loader.sv
module cfg_bitbang_loader
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              cfgStrobe,
  input  logic              cfgData,
  output logic              fabricRst,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic [ADDR_W-1:0] wordAddr
);

  logic [2:0]   syncBus;
  logic         loadEn;
  ctrlStrobes_t ctl;

  cfg_loader_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
    .clk     (clk),
    .porN    (porN),
    .asyncIn ({rstN, cfgData, cfgStrobe}),
    .syncOut (syncBus)
  );

  cfg_loader_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .porN       (porN),
    .strobeSync (syncBus[0]),
    .rstNSync   (syncBus[2]),
    .ctl        (ctl),
    .loadEn     (loadEn)
  );

  cfg_loader_dpath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .porN      (porN),
    .ctl       (ctl),
    .dataSync  (syncBus[1]),
    .wordValid (wordValid),
    .wordData  (wordData),
    .wordAddr  (wordAddr)
  );

  assign fabricRst = loadEn;

endmodule

// File: rtl/cfg_bitbang_loader_chk.sv
module cfg_bitbang_loader_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              porN,
  input logic              fabricRst,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordData,
  input logic [ADDR_W-1:0] wordAddr
);

  logic              seenWord;
  logic [ADDR_W-1:0] lastAddr;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      seenWord <= 1'b0;
      lastAddr <= '0;
    end else if (!fabricRst) begin
      seenWord <= 1'b0;
    end else if (wordValid) begin
      seenWord <= 1'b1;
      lastAddr <= wordAddr;
    end
  end

  // R5
  addr_first_chk: assert property (@(posedge clk) disable iff (!porN)
    (wordValid && !seenWord) |-> (wordAddr == '0));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!porN)
    (wordValid && seenWord) |-> (wordAddr == ADDR_W'(lastAddr + 1'b1)));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!porN)
    wordValid |=> !wordValid);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!porN)
    !fabricRst |=> !wordValid);

  // R3
  data_known_chk: assert property (@(posedge clk) disable iff (!porN)
    wordValid |-> !$isunknown(wordData));

endmodule

bind cfg_bitbang_loader cfg_bitbang_loader_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .porN      (porN),
  .fabricRst (fabricRst),
  .wordValid (wordValid),
  .wordData  (wordData),
  .wordAddr  (wordAddr)
);

// File: tb/cfg_bitbang_loader_bench.sv
module cfg_bitbang_loader_bench;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 6;
  localparam int NWORDS = 1 << ADDR_W;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic rstN = 1'b0;
  logic cfgStrobe = 1'b0;
  logic cfgData = 1'b0;
  logic fabricRst;
  logic wordValid;
  logic [WORD_W-1:0] wordData;
  logic [ADDR_W-1:0] wordAddr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit started = 0;

  always #2 clk = ~clk;

  cfg_bitbang_loader #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_cfg_bitbang_loader (
    .clk(clk), .porN(porN), .rstN(rstN), .cfgStrobe(cfgStrobe), .cfgData(cfgData),
    .fabricRst(fabricRst), .wordValid(wordValid), .wordData(wordData), .wordAddr(wordAddr)
  );

  // behavioural reference: history of sampled pins and a word accumulator
  bit hS[3], hD[3], hR[3];
  int mCnt = 0;
  int mAddr = 0;
  logic [WORD_W-1:0] mShift = '0;
  bit expValid = 0;
  bit expFab = 1;
  logic [WORD_W-1:0] expWord = '0;
  int expAddr = 0;

  logic [WORD_W-1:0] gotWords[$];
  int gotAddrs[$];

  always @(posedge clk) begin
    if (!porN) begin
      for (int i = 0; i < 3; i++) begin hS[i] = 0; hD[i] = 0; hR[i] = 0; end
      mCnt = 0; mAddr = 0; mShift = '0; expValid = 0; expFab = 1;
    end else begin
      expValid = 0;
      if (hR[1]) begin
        mCnt = 0; mAddr = 0;
      end else if (hS[1] && !hS[2]) begin
        mShift = {mShift[WORD_W-2:0], hD[1]};
        mCnt++;
        if (mCnt == WORD_W) begin
          expValid = 1; expWord = mShift; expAddr = mAddr;
          mAddr = (mAddr + 1) % NWORDS; mCnt = 0;
        end
      end
      for (int i = 2; i > 0; i--) begin hS[i] = hS[i-1]; hD[i] = hD[i-1]; hR[i] = hR[i-1]; end
      hS[0] = cfgStrobe; hD[0] = cfgData; hR[0] = rstN;
      expFab = !hR[1];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check(fabricRst === expFab, "R8", "fabricRst", fabricRst, expFab);
      check(wordValid === expValid, "R4", "wordValid", wordValid, expValid);
      if (expValid && wordValid) begin
        check(wordData === expWord, "R3", "wordData", wordData, expWord);
        check(int'(wordAddr) == expAddr, "R5", "wordAddr", wordAddr, expAddr);
      end
      if (wordValid) begin
        gotWords.push_back(wordData);
        gotAddrs.push_back(int'(wordAddr));
      end
    end
  end

  task automatic sendBit(input bit b, input int hi, input int lo);
    @(negedge clk);
    cfgData = b;
    cfgStrobe = 1'b1;
    repeat (hi - 1) @(negedge clk);
    @(negedge clk);
    cfgStrobe = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic sendWord(input logic [WORD_W-1:0] w, input int hi, input int lo);
    for (int i = WORD_W - 1; i >= 0; i--) sendBit(w[i], hi, lo);
    repeat (5) @(negedge clk);
  endtask

  task automatic expectWord(input int idx, input logic [WORD_W-1:0] w,
                            input int a, input string req);
    check(gotWords.size() > idx, req, "word count", gotWords.size(), idx + 1);
    if (gotWords.size() > idx) begin
      check(gotWords[idx] === w, req, "word value", gotWords[idx], w);
      check(gotAddrs[idx] == a, req, "word address", gotAddrs[idx], a);
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check(0, "R4", "watchdog expired", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: state held by the power-on reset
    check(wordValid === 1'b0, "R1", "wordValid in reset", wordValid, 0);
    check(fabricRst === 1'b1, "R1", "fabricRst in reset", fabricRst, 1);
    porN = 1'b1;
    started = 1;
    repeat (4) @(negedge clk);

    // R3 R4 R5: three words with different strobe timings; R2 via long high levels
    sendWord(32'hA5C3_0F96, 1, 1);
    sendWord(32'h8000_0001, 6, 2);
    sendWord(32'h7FFF_FFFE, 1, 5);
    expectWord(0, 32'hA5C3_0F96, 0, "R3");
    expectWord(1, 32'h8000_0001, 1, "R2");
    expectWord(2, 32'h7FFF_FFFE, 2, "R5");

    // R7: partial word, then release the chip reset
    for (int i = 0; i < 10; i++) sendBit(1'b1, 1, 1);
    @(negedge clk); rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(fabricRst === 1'b0, "R8", "fabricRst after release", fabricRst, 0);

    // R6: strobe activity in user mode produces nothing
    base = gotWords.size();
    for (int i = 0; i < 40; i++) sendBit(i[0], 1, 1);
    repeat (5) @(negedge clk);
    check(gotWords.size() == base, "R6", "words while idle", gotWords.size(), base);

    // R7: new load starts at address 0 with a fresh word
    @(negedge clk); rstN = 1'b0;
    repeat (4) @(negedge clk);
    check(fabricRst === 1'b1, "R8", "fabricRst after reentry", fabricRst, 1);
    sendWord(32'h1234_5678, 2, 3);
    expectWord(base, 32'h1234_5678, 0, "R7");

    // R5: address wraps after 2^ADDR_W words
    base = gotWords.size();
    for (int k = 0; k < NWORDS; k++) sendWord(WORD_W'(k) * 32'h0101_0101 ^ 32'hC33C_5AA5, 1, 1);
    expectWord(base + NWORDS - 2, WORD_W'(NWORDS - 2) * 32'h0101_0101 ^ 32'hC33C_5AA5,
               NWORDS - 1, "R5");
    expectWord(base + NWORDS - 1, WORD_W'(NWORDS - 1) * 32'h0101_0101 ^ 32'hC33C_5AA5,
               0, "R5");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule